// File: doc/BRIEF.md
# Shared-pin GPIO port controller

This block arbitrates an eight-bit I/O port among three kinds of user. These are a pair of stall-detect units, a set of motor-control PWM channels and plain general-purpose I/O. Each pin is given to one owner by a fixed order of precedence. The port is split into two halves. Stall-detect unit 1 or the upper PWM group can take the upper half. Stall-detect unit 0 or the lower PWM group can take the lower half. Each PWM channel covers two adjacent pins: channel k drives pins 2k+1 and 2k.

Software reaches the port through a small register bus with three registers: pin data, pin direction and slew enable. Reads of the data register return one of three things for each bit. An output bit returns the stored bit. An input bit returns a constant 1 while slew control is on. An input bit with slew off returns the synchronised pin level. The pad side of the block is a tri-state output value and output-enable pair, plus the raw pin inputs. The synchronised pin levels are also handed back to the peripherals.

Top module: `port_mux_ctrl`

## Requirements
- R1: While rst_ni is low, every bit of pad_oe_o is 0 whatever the peripheral inputs are. After reset the data, direction and slew registers all hold 0x00.
- R2: The register offsets on bus_addr_i are 0 = data, 1 = direction and 2 = slew enable. Offset 3 reads 0x00. bus_rdata_o shows the register at the current address combinationally, and every register can be written at any time.
- R3: A write with bus_we_i high updates the addressed register at the rising clock edge that samples the strobe. When bus_we_i is low, no register changes.
- R4: While stall_en_i[1] is 1, pins 7..4 take pad_out_o and pad_oe_o from stall_out_i and stall_oe_i. This holds whatever the PWM enables and the registers contain.
- R5: While stall_en_i[0] is 1, pins 3..0 take pad_out_o and pad_oe_o from stall_out_i and stall_oe_i.
- R6: The PWM rule applies when the stall-detect unit of a half is off. In that case, if pwm_ch_en_i[k] is 1, pins 2k+1 and 2k take their output and enable from pwm_out_i and pwm_oe_i.
- R7: A pin owned by neither a stall-detect unit nor a PWM channel drives the data register bit on pad_out_o and the direction register bit on pad_oe_o.
- R8: Reading offset 0 returns the stored data bit for each pin whose direction bit is 1.
- R9: Reading offset 0 returns 1 for each pin whose direction bit is 0 and whose slew bit is 1.
- R10: Reading offset 0 returns the synchronised pin level for each pin whose direction bit and slew bit are both 0. That level is pad_in_i as sampled two rising edges earlier.
- R11: periph_in_o carries the same two-flop synchronised pad_in_i to the peripherals. It resets to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| stall_en_i | input | 2 | Stall-detect unit enables; bit 1 covers the upper half |
| pwm_ch_en_i | input | 4 | PWM channel enables; channel k covers pins 2k+1, 2k |
| stall_out_i | input | 8 | Stall-detect output values per pin |
| stall_oe_i | input | 8 | Stall-detect output enables per pin |
| pwm_out_i | input | 8 | PWM output values per pin |
| pwm_oe_i | input | 8 | PWM output enables per pin |
| pad_in_i | input | 8 | Raw pin levels |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |
| periph_in_o | output | 8 | Synchronised pin levels for the peripherals |

## Verification
The bench builds the block with its default parameters: an eight-pin port and two synchroniser stages. That gives two four-pin halves and four two-pin PWM channels. With that size, every combination of stall enable, PWM enable and direction/slew setting can be reached on some pin. The reference model delays pin levels through a two-entry queue, so the two-edge read-back latency is checked exactly. A long random phase then mixes bus writes and enable changes, so that ownership changes on pins whose registers are being rewritten in the same cycle.

// File: rtl/port_mux_pkg.sv
package port_mux_pkg;
  localparam int unsigned BUS_AW = 2;

  localparam logic [BUS_AW-1:0] OFS_DATA = 2'd0;
  localparam logic [BUS_AW-1:0] OFS_DIR  = 2'd1;
  localparam logic [BUS_AW-1:0] OFS_SLEW = 2'd2;

  typedef enum logic [1:0] {
    OWN_GPIO  = 2'd0,
    OWN_PWM   = 2'd1,
    OWN_STALL = 2'd2
  } pin_owner_e;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= din_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout_o = stg_q[STAGES-1];
endmodule

// File: rtl/pm_regs.sv
module pm_regs
  import port_mux_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      pin_sync_i,
  output logic [W-1:0]      data_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      rdata_o
);
  logic [W-1:0] data_q, dir_q, slew_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      slew_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        OFS_DATA: data_q <= wdata_i;
        OFS_DIR:  dir_q  <= wdata_i;
        OFS_SLEW: slew_q <= wdata_i;
        default:  ;
      endcase
    end
  end

  // input bits: slew on reads 1, slew off reads the synced pin
  always_comb begin
    unique case (addr_i)
      OFS_DATA: rdata_o = (dir_q & data_q) | (~dir_q & (slew_q | pin_sync_i));
      OFS_DIR:  rdata_o = dir_q;
      OFS_SLEW: rdata_o = slew_q;
      default:  rdata_o = '0;
    endcase
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;

  AST_DATA_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_DATA) |=> (data_q == $past(wdata_i))) else $error("data write"); // R3

  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(data_q) && $stable(dir_q) && $stable(slew_q))) else $error("reg hold"); // R3

  for (genvar i = 0; i < W; i++) begin : g_slew_chk
    AST_SLEW_READ_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == OFS_DATA && !dir_q[i] && slew_q[i]) |-> rdata_o[i]) else $error("slew read"); // R9
  end
endmodule

// File: rtl/pm_owner_mux.sv
module pm_owner_mux
  import port_mux_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic           live_i,
  input  logic [1:0]     stall_en_i,
  input  logic [W/2-1:0] pwm_ch_en_i,
  input  logic [W-1:0]   stall_out_i,
  input  logic [W-1:0]   stall_oe_i,
  input  logic [W-1:0]   pwm_out_i,
  input  logic [W-1:0]   pwm_oe_i,
  input  logic [W-1:0]   gpio_data_i,
  input  logic [W-1:0]   gpio_dir_i,
  output logic [W-1:0]   pad_out_o,
  output logic [W-1:0]   pad_oe_o
);
  localparam int unsigned HALF = W / 2;

  for (genvar i = 0; i < W; i++) begin : g_pin
    localparam int unsigned HF = i / HALF;
    localparam int unsigned CH = i / 2;
    pin_owner_e owner;

    always_comb begin
      if (stall_en_i[HF])       owner = OWN_STALL;
      else if (pwm_ch_en_i[CH]) owner = OWN_PWM;
      else                      owner = OWN_GPIO;
    end

    always_comb begin
      unique case (owner)
        OWN_STALL: begin pad_out_o[i] = stall_out_i[i]; pad_oe_o[i] = stall_oe_i[i] & live_i; end
        OWN_PWM:   begin pad_out_o[i] = pwm_out_i[i];   pad_oe_o[i] = pwm_oe_i[i]   & live_i; end
        default:   begin pad_out_o[i] = gpio_data_i[i]; pad_oe_o[i] = gpio_dir_i[i] & live_i; end
      endcase
    end
  end
endmodule

// File: rtl/port_mux_ctrl.sv
module port_mux_ctrl
  import port_mux_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  input  logic [1:0]        stall_en_i,
  input  logic [W/2-1:0]    pwm_ch_en_i,
  input  logic [W-1:0]      stall_out_i,
  input  logic [W-1:0]      stall_oe_i,
  input  logic [W-1:0]      pwm_out_i,
  input  logic [W-1:0]      pwm_oe_i,
  input  logic [W-1:0]      pad_in_i,
  output logic [W-1:0]      pad_out_o,
  output logic [W-1:0]      pad_oe_o,
  output logic [W-1:0]      periph_in_o
);
  localparam int unsigned HALF = W / 2;
  localparam int unsigned NCH  = W / 2;

  logic [W-1:0] pin_sync, data_q, dir_q;

  pm_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(pad_in_i), .dout_o(pin_sync)
  );

  pm_regs #(.W(W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .pin_sync_i(pin_sync),
    .data_o(data_q), .dir_o(dir_q), .rdata_o(bus_rdata_o)
  );

  pm_owner_mux #(.W(W)) u_mux (
    .live_i(rst_ni), .stall_en_i(stall_en_i), .pwm_ch_en_i(pwm_ch_en_i),
    .stall_out_i(stall_out_i), .stall_oe_i(stall_oe_i),
    .pwm_out_i(pwm_out_i), .pwm_oe_i(pwm_oe_i),
    .gpio_data_i(data_q), .gpio_dir_i(dir_q),
    .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o)
  );

  assign periph_in_o = pin_sync;

  always_comb begin
    if (!rst_ni) AST_RESET_HIZ: assert (pad_oe_o == '0) else $error("reset hiz"); // R1
  end

  AST_STALL_HI_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_en_i[1] |-> (pad_out_o[W-1:HALF] == stall_out_i[W-1:HALF] &&
                       pad_oe_o[W-1:HALF]  == stall_oe_i[W-1:HALF])) else $error("stall hi"); // R4

  AST_STALL_LO_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_en_i[0] |-> (pad_out_o[HALF-1:0] == stall_out_i[HALF-1:0] &&
                       pad_oe_o[HALF-1:0]  == stall_oe_i[HALF-1:0])) else $error("stall lo"); // R5

  for (genvar c = 0; c < NCH; c++) begin : g_ch_chk
    localparam int unsigned HF = (2 * c) / HALF;
    AST_PWM_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_en_i[HF] && pwm_ch_en_i[c]) |->
        (pad_out_o[2*c+1 -: 2] == pwm_out_i[2*c+1 -: 2] &&
         pad_oe_o[2*c+1 -: 2]  == pwm_oe_i[2*c+1 -: 2])) else $error("pwm owns"); // R6
    AST_GPIO_FALLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_en_i[HF] && !pwm_ch_en_i[c]) |->
        (pad_out_o[2*c+1 -: 2] == data_q[2*c+1 -: 2] &&
         pad_oe_o[2*c+1 -: 2]  == dir_q[2*c+1 -: 2])) else $error("gpio fallback"); // R7
  end
endmodule

// File: tb/port_mux_ctrl_test.sv
`timescale 1ns/1ps
module port_mux_ctrl_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       we = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [1:0] stall_en = 0;
  logic [3:0] pwm_en = 0;
  logic [7:0] stall_out = 0, stall_oe = 0, pwm_out = 0, pwm_oe = 0, pad_in = 0;
  logic [7:0] pad_out, pad_oe, periph_in;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  port_mux_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .stall_en_i(stall_en),
    .pwm_ch_en_i(pwm_en), .stall_out_i(stall_out), .stall_oe_i(stall_oe),
    .pwm_out_i(pwm_out), .pwm_oe_i(pwm_oe), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .periph_in_o(periph_in)
  );

  // reference model
  logic [7:0] m_data, m_dir, m_slew;
  logic [7:0] m_hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = 0; m_dir = 0; m_slew = 0;
      m_hist = '{8'h00, 8'h00};
    end else begin
      if (we) begin
        if (addr == 2'd0) m_data = wdata;
        else if (addr == 2'd1) m_dir = wdata;
        else if (addr == 2'd2) m_slew = wdata;
      end
      m_hist.push_back(pad_in);
      void'(m_hist.pop_front());
    end
  end

  task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic [7:0] sync_v;
      sync_v = m_hist[0];
      for (int i = 0; i < 8; i++) begin
        int hf;
        bit e_out, e_oe;
        string tag;
        hf = i / 4;
        if (!rst_n) begin
          chk(pad_oe[i] == 1'b0, "R1 reset oe", {7'b0, pad_oe[i]}, 8'h0);
        end else begin
          if (stall_en[hf]) begin
            e_out = stall_out[i]; e_oe = stall_oe[i];
            tag = (hf == 1) ? "R4 stall1 pin" : "R5 stall0 pin";
          end else if (pwm_en[i/2]) begin
            e_out = pwm_out[i]; e_oe = pwm_oe[i]; tag = "R6 pwm pin";
          end else begin
            e_out = m_data[i]; e_oe = m_dir[i]; tag = "R7 gpio pin";
          end
          chk(pad_out[i] == e_out && pad_oe[i] == e_oe, tag,
              {6'b0, pad_out[i], pad_oe[i]}, {6'b0, e_out, e_oe});
        end
      end
      case (addr)
        2'd0: for (int i = 0; i < 8; i++) begin
          bit e;
          string tag;
          if (m_dir[i]) begin e = m_data[i]; tag = "R8 out readback"; end
          else if (m_slew[i]) begin e = 1'b1; tag = "R9 slew readback"; end
          else begin e = sync_v[i]; tag = "R10 pin readback"; end
          chk(rdata[i] == e, tag, {7'b0, rdata[i]}, {7'b0, e});
        end
        2'd1: chk(rdata == m_dir, "R2 R3 dir read", rdata, m_dir);
        2'd2: chk(rdata == m_slew, "R2 R3 slew read", rdata, m_slew);
        default: chk(rdata == 8'h00, "R2 unused offset", rdata, 8'h00);
      endcase
      chk(periph_in == sync_v, "R11 periph in", periph_in, sync_v);
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    we = 1; addr = a; wdata = d;
    step();
    we = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: peripherals request drive during reset
    stall_en = 2'b11; pwm_en = 4'hF; stall_oe = 8'hFF; pwm_oe = 8'hFF;
    step(3);
    rst_n = 1;
    stall_en = 0; pwm_en = 0; stall_oe = 0; pwm_oe = 0;
    addr = 2'd1; step(); addr = 2'd2; step(); addr = 2'd0; step();
    // R3 R8 R10 gpio
    pad_in = 8'h3C;
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'hA5);
    addr = 2'd0; step(3);
    pad_in = 8'hC3; step(3);
    // R9 slew
    wr(2'd2, 8'h0F);
    addr = 2'd0; step(2);
    addr = 2'd3; step();
    addr = 2'd2; step();
    // R6 pwm
    pwm_out = 8'h5A; pwm_oe = 8'hCC; pwm_en = 4'b0101; step(2);
    pwm_en = 4'b1010; step(2);
    // R4 R5 stall priority
    stall_out = 8'h96; stall_oe = 8'h69;
    stall_en = 2'b01; step(2);
    stall_en = 2'b10; step(2);
    stall_en = 2'b11; step(2);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      we = ($urandom_range(0, 3) == 0);
      addr = 2'($urandom_range(0, 3));
      wdata = 8'($urandom);
      pad_in = 8'($urandom);
      stall_en = 2'($urandom);
      pwm_en = 4'($urandom);
      stall_out = 8'($urandom); stall_oe = 8'($urandom);
      pwm_out = 8'($urandom); pwm_oe = 8'($urandom);
      if (k == 1500) begin rst_n = 0; step(); rst_n = 1; end
      step();
    end
    we = 0;
    step(2);
    finish_run();
  end
endmodule